// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block is a wall clock of tenths of a second, seconds, minutes and hours with a morning/afternoon flag. All fields are binary-coded decimal. A synchronous reference strobe at 50 Hz or 60 Hz drives it. A prescaler turns that strobe into one tenth-of-a-second tick, and the tick ripples through the BCD counters on a twelve-hour dial.

A small register port gives access to the clock. Reading the hours field freezes a coherent copy of all four fields, and that copy is served until the tenths field is read. Writing the hours field stops the clock, and writing the tenths field starts it again, so software can load a full time without a carry slipping in. A mode input sends writes to a separate set of alarm registers. A one-cycle alarm event is raised when the running time becomes equal to the alarm setting.

Two small state machines set the control behaviour. The run machine has the states RUN and HALT. A time write to hours moves it RUN to HALT, and a time write to tenths moves it HALT to RUN. The read machine has the states LIVE and HELD. A read of hours moves it LIVE to HELD and captures the snapshot. A read of tenths moves it HELD to LIVE. Every other access keeps both machines where they are.

Top module: `tod_clock`

## Requirements
- R1: After reset the time is 12:00:00.0 AM: hours reads 0x12, the other fields read 0x00, and alarm_evt is low.
- R2: With sel_50hz=0 the tenths field advances once per 6 ref_tick strobes; with sel_50hz=1 it advances once per 5.
- R3: Tenths counts 0 to 9 and then wraps to 0 with a carry into seconds. Seconds and minutes count 00 to 59 and wrap to 00 with a carry into the next field. All counts are BCD.
- R4: The hours field (read bits 4:0) steps 12→01, 09→10 and 11→12. Bit 7 of the hours read is 1 for PM, and it toggles on the 11→12 step.
- R5: Register addresses are tenths=0, seconds=1, minutes=2, hours=3. A read strobe of hours freezes a snapshot of all four fields. While the snapshot is frozen, rdata returns snapshot values. A read strobe of tenths releases it.
- R6: A time write to hours stops the clock, and a time write to tenths restarts it. While the clock is stopped, reference strobes have no effect and the prescaler is cleared, so after the restart the first tick needs a full prescale count.
- R7: With alarm_sel=1, writes update the alarm registers and leave the time and the run state unchanged. rdata always shows time, never the alarm.
- R8: When the time registers become equal to the alarm registers (all four fields and the PM flag), alarm_evt pulses high for exactly one cycle, one cycle later.
- R9: A time write takes precedence over a tick in the same cycle, and that tick is lost. Unused bits are dropped on write and read as 0: tenths keeps bits 3:0, seconds and minutes keep 6:0, and hours keeps bit 7 and bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference period (50/60 Hz) |
| sel_50hz | input | 1 | 1 = reference is 50 Hz, 0 = 60 Hz |
| alarm_sel | input | 1 | 1 = writes target the alarm registers |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (drives snapshot control) |
| addr | input | 2 | Field select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Selected time field (combinational from addr) |
| alarm_evt | output | 1 | One-cycle alarm event |

## Verification
A wrong run or read state shows at the ports within one cycle. A clock that failed to halt changes tenths on the next completing prescale count, and a snapshot that failed to freeze makes rdata track live time at the next tick. A prescaler off by one count moves the tenths step by a single cycle. The reference model compares rdata and alarm_evt on every clock, so such errors appear within one tick period of at most six strobes. A carry or AM/PM slip shows on the wrap cycle itself, and the directed boundary times are aimed at exactly those cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef struct packed {
        logic [3:0] ten;
        logic [6:0] sec;
        logic [6:0] min;
        logic       pm;
        logic [4:0] hr;
    } tod_t;

    typedef enum logic {ST_RUN, ST_HALT} run_st_e;
    typedef enum logic {ST_LIVE, ST_HELD} rd_st_e;

    localparam logic [1:0] ADR_TEN = 2'd0;
    localparam logic [1:0] ADR_SEC = 2'd1;
    localparam logic [1:0] ADR_MIN = 2'd2;
    localparam logic [1:0] ADR_HR  = 2'd3;

    localparam tod_t TOD_RESET = '{ten: 4'h0, sec: 7'h00, min: 7'h00, pm: 1'b0, hr: 5'h12};

    function automatic logic [6:0] bcd59_inc(input logic [6:0] v);
        if (v == 7'h59)         return 7'h00;
        else if (v[3:0] == 4'h9) return {v[6:4] + 3'd1, 4'h0};
        else                    return v + 7'd1;
    endfunction

    function automatic logic [4:0] hr_inc(input logic [4:0] v);
        if (v == 5'h12)         return 5'h01;
        else if (v == 5'h09)    return 5'h10;
        else                    return v + 5'd1;
    endfunction

endpackage

// File: rtl/tod_prescale.sv
module tod_prescale #(
    parameter int DIV_50 = 5,
    parameter int DIV_60 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_tick,
    input  logic sel_50hz,
    output logic tick
);
    localparam int MAXD = (DIV_60 > DIV_50) ? DIV_60 : DIV_50;
    localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = sel_50hz ? CW'(DIV_50 - 1) : CW'(DIV_60 - 1);
    assign tick = ref_tick && !clr && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else if (ref_tick)  cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/tod_ctl.sv
module tod_ctl
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       alarm_sel,
    input  logic [1:0] addr,
    output logic       halted,
    output logic       held,
    output logic       snap_en
);
    run_st_e run_q, run_d;
    rd_st_e  rd_q,  rd_d;
    logic    twr;

    assign twr = wr_en && !alarm_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= ST_RUN;
            rd_q  <= ST_LIVE;
        end else begin
            run_q <= run_d;
            rd_q  <= rd_d;
        end
    end

    always_comb begin
        run_d   = run_q;
        rd_d    = rd_q;
        snap_en = 1'b0;
        unique case (run_q)
            ST_RUN:  if (twr && addr == ADR_HR)  run_d = ST_HALT;
            ST_HALT: if (twr && addr == ADR_TEN) run_d = ST_RUN;
        endcase
        unique case (rd_q)
            ST_LIVE: if (rd_en && addr == ADR_HR) begin
                rd_d    = ST_HELD;
                snap_en = 1'b1;
            end
            ST_HELD: if (rd_en && addr == ADR_TEN) rd_d = ST_LIVE;
        endcase
    end

    assign halted = (run_q == ST_HALT);
    assign held   = (rd_q == ST_HELD);
endmodule

// File: rtl/tod_time.sv
module tod_time
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output tod_t       now
);
    tod_t q, d;
    logic c_ten, c_sec, c_min;

    assign c_ten = tick && (q.ten == 4'h9);
    assign c_sec = c_ten && (q.sec == 7'h59);
    assign c_min = c_sec && (q.min == 7'h59);

    always_comb begin
        d = q;
        if (we) begin
            unique case (addr)
                ADR_TEN: d.ten = wdata[3:0];
                ADR_SEC: d.sec = wdata[6:0];
                ADR_MIN: d.min = wdata[6:0];
                ADR_HR: begin
                    d.hr = wdata[4:0];
                    d.pm = wdata[7];
                end
            endcase
        end else if (tick) begin
            d.ten = c_ten ? 4'h0 : q.ten + 4'h1;
            if (c_ten) d.sec = bcd59_inc(q.sec);
            if (c_sec) d.min = bcd59_inc(q.min);
            if (c_min) begin
                d.hr = hr_inc(q.hr);
                if (q.hr == 5'h11) d.pm = !q.pm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= TOD_RESET;
        else        q <= d;
    end

    assign now = q;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int DIV_50 = 5,
    parameter int DIV_60 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       sel_50hz,
    input  logic       alarm_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       alarm_evt
);
    logic halted, held, snap_en, tick;
    tod_t live, snap_q, alarm_q, view;
    logic eq, eq_q, evt_q;

    tod_prescale #(.DIV_50(DIV_50), .DIV_60(DIV_60)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(halted), .ref_tick(ref_tick),
        .sel_50hz(sel_50hz), .tick(tick)
    );

    tod_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .alarm_sel(alarm_sel), .addr(addr), .halted(halted), .held(held),
        .snap_en(snap_en)
    );

    tod_time u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick), .we(wr_en && !alarm_sel),
        .addr(addr), .wdata(wdata), .now(live)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= TOD_RESET;
            alarm_q <= TOD_RESET;
            eq_q    <= 1'b1;
            evt_q   <= 1'b0;
        end else begin
            if (snap_en) snap_q <= live;
            if (wr_en && alarm_sel) begin
                unique case (addr)
                    ADR_TEN: alarm_q.ten <= wdata[3:0];
                    ADR_SEC: alarm_q.sec <= wdata[6:0];
                    ADR_MIN: alarm_q.min <= wdata[6:0];
                    ADR_HR: begin
                        alarm_q.hr <= wdata[4:0];
                        alarm_q.pm <= wdata[7];
                    end
                endcase
            end
            eq_q  <= eq;
            evt_q <= eq && !eq_q;
        end
    end

    assign eq        = (live == alarm_q);
    assign alarm_evt = evt_q;
    assign view      = held ? snap_q : live;

    always_comb begin
        unique case (addr)
            ADR_TEN: rdata = {4'h0, view.ten};
            ADR_SEC: rdata = {1'b0, view.sec};
            ADR_MIN: rdata = {1'b0, view.min};
            ADR_HR:  rdata = {view.pm, 2'b00, view.hr};
        endcase
    end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       halted,
    input logic       held,
    input logic       rd_en,
    input logic [1:0] addr,
    input tod_t       snap_q,
    input tod_t       live,
    input logic       alarm_evt
);
    // R2: ticks never arrive on back-to-back cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R6: no tick leaves the prescaler while the clock is stopped
    a_r6_no_tick_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !tick);

    // R5: frozen snapshot holds until a tenths read
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(rd_en && addr == ADR_TEN)) |=> $stable(snap_q));

    // R8: alarm event lasts a single cycle
    a_r8_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt);

    // R4: hours stays on the twelve-hour dial after ticks
    a_r4_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) |-> (live.hr >= 5'h01 && live.hr <= 5'h12));
endmodule

bind tod_clock tod_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halted(halted), .held(held),
    .rd_en(rd_en), .addr(addr), .snap_q(snap_q), .live(live),
    .alarm_evt(alarm_evt)
);

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0, sel_50hz = 1'b0, alarm_sel = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       alarm_evt;

    int checks = 0, errors = 0, evt_cnt = 0;
    string cur_req = "R1";

    tod_clock dut (.*);

    always #2 clk = ~clk;

    // reference model state: [0] tenths [1] sec [2] min [3] hour [4] pm
    int m_t[5], m_s[5], m_a[5];
    int m_cnt, m_halt, m_held, m_eqq, m_evt;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] field(input int a, input int f0, input int f1,
                                         input int f2, input int f3, input int f4);
        case (a)
            0: return i2b(f0);
            1: return i2b(f1);
            2: return i2b(f2);
            default: return (f4 != 0 ? 8'h80 : 8'h00) | i2b(f3);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = '{0, 0, 0, 12, 0};
            m_a = '{0, 0, 0, 12, 0};
            m_s = '{0, 0, 0, 12, 0};
            m_cnt = 0; m_halt = 0; m_held = 0; m_eqq = 1; m_evt = 0;
        end else begin
            int tk, eq_old, dv;
            tk = 0;
            eq_old = (m_t == m_a) ? 1 : 0;
            dv = sel_50hz ? 5 : 6;
            if (m_halt != 0) m_cnt = 0;
            else if (ref_tick) begin
                if (m_cnt >= dv - 1) begin tk = 1; m_cnt = 0; end
                else m_cnt++;
            end
            if (rd_en) begin
                if (m_held == 0 && addr == 2'd3) begin m_s = m_t; m_held = 1; end
                else if (m_held != 0 && addr == 2'd0) m_held = 0;
            end
            if (wr_en && !alarm_sel) begin
                case (addr)
                    2'd0: begin m_t[0] = int'(wdata[3:0]); m_halt = 0; end
                    2'd1: m_t[1] = b2i({1'b0, wdata[6:0]});
                    2'd2: m_t[2] = b2i({1'b0, wdata[6:0]});
                    default: begin
                        m_t[3] = b2i({3'b0, wdata[4:0]}); m_t[4] = int'(wdata[7]); m_halt = 1;
                    end
                endcase
            end else if (tk != 0) begin
                m_t[0]++;
                if (m_t[0] == 10) begin
                    m_t[0] = 0; m_t[1]++;
                    if (m_t[1] == 60) begin
                        m_t[1] = 0; m_t[2]++;
                        if (m_t[2] == 60) begin
                            m_t[2] = 0;
                            if (m_t[3] == 11) begin m_t[3] = 12; m_t[4] = 1 - m_t[4]; end
                            else if (m_t[3] == 12) m_t[3] = 1;
                            else m_t[3]++;
                        end
                    end
                end
            end
            if (wr_en && alarm_sel) begin
                case (addr)
                    2'd0: m_a[0] = int'(wdata[3:0]);
                    2'd1: m_a[1] = b2i({1'b0, wdata[6:0]});
                    2'd2: m_a[2] = b2i({1'b0, wdata[6:0]});
                    default: begin m_a[3] = b2i({3'b0, wdata[4:0]}); m_a[4] = int'(wdata[7]); end
                endcase
            end
            m_evt = (eq_old != 0 && m_eqq == 0) ? 1 : 0;
            m_eqq = eq_old;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            logic [7:0] exp_rd;
            if (m_held != 0) exp_rd = field(int'(addr), m_s[0], m_s[1], m_s[2], m_s[3], m_s[4]);
            else             exp_rd = field(int'(addr), m_t[0], m_t[1], m_t[2], m_t[3], m_t[4]);
            checks++;
            if (rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s model rdata addr=%0d actual=%02h expected=%02h", cur_req, addr, rdata, exp_rd);
            end
            checks++;
            if (alarm_evt !== (m_evt != 0)) begin
                errors++;
                $display("FAIL R8 model alarm_evt actual=%0b expected=%0d", alarm_evt, m_evt);
            end
            if (alarm_evt) evt_cnt++;
        end
    end

    task automatic drive(input logic rf, input logic w, input logic r,
                         input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        ref_tick = rf; wr_en = w; rd_en = r; addr = a; wdata = d;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        drive(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string req);
        drive(1'b0, 1'b0, 1'b0, a, 8'h00);
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rdata, exp);
        end
    endtask

    task automatic check_val(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        peek(2'd0, 8'h00, "R1"); peek(2'd1, 8'h00, "R1");
        peek(2'd2, 8'h00, "R1"); peek(2'd3, 8'h12, "R1");
        check_val(int'(alarm_evt), 0, "R1");

        // R2 prescale at 60 Hz then 50 Hz
        cur_req = "R2";
        pulses(5); peek(2'd0, 8'h00, "R2");
        pulses(1); peek(2'd0, 8'h01, "R2");
        sel_50hz = 1'b1;
        pulses(4); peek(2'd0, 8'h01, "R2");
        pulses(1); peek(2'd0, 8'h02, "R2");

        // R3/R4 full wrap 11:59:59.9 PM -> 12:00:00.0 AM
        cur_req = "R3";
        wr(2'd3, 8'h91); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h09);
        pulses(5);
        peek(2'd0, 8'h00, "R3"); peek(2'd1, 8'h00, "R3"); peek(2'd2, 8'h00, "R3");
        peek(2'd3, 8'h12, "R4");
        // 11:59:59.9 AM -> 12 PM
        cur_req = "R4";
        wr(2'd3, 8'h11); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h09);
        pulses(5); peek(2'd3, 8'h92, "R4");
        // 09 -> 10
        wr(2'd3, 8'h09); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h09);
        pulses(5); peek(2'd3, 8'h10, "R4");
        // 12 -> 01
        wr(2'd3, 8'h12); wr(2'd2, 8'h59); wr(2'd1, 8'h59); wr(2'd0, 8'h09);
        pulses(5); peek(2'd3, 8'h01, "R4"); peek(2'd0, 8'h00, "R3");

        // R5 snapshot
        cur_req = "R5";
        drive(1'b0, 1'b0, 1'b1, 2'd3, 8'h00);
        pulses(12);
        peek(2'd0, 8'h00, "R5"); peek(2'd3, 8'h01, "R5");
        drive(1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
        peek(2'd0, 8'h02, "R5");

        // R6 halt and restart, R9 masking
        cur_req = "R6";
        wr(2'd3, 8'h65);
        pulses(20);
        peek(2'd0, 8'h02, "R6"); peek(2'd3, 8'h05, "R9");
        wr(2'd0, 8'h37);
        peek(2'd0, 8'h07, "R9");
        pulses(4); peek(2'd0, 8'h07, "R6");
        pulses(1); peek(2'd0, 8'h08, "R6");

        // R9 write beats tick
        cur_req = "R9";
        pulses(4);
        drive(1'b1, 1'b1, 1'b0, 2'd1, 8'h33);
        peek(2'd0, 8'h08, "R9"); peek(2'd1, 8'h33, "R9");
        wr(2'd2, 8'h85); peek(2'd2, 8'h05, "R9");
        wr(2'd0, 8'h08);

        // R7 alarm redirection
        cur_req = "R7";
        alarm_sel = 1'b1;
        wr(2'd3, 8'h05); wr(2'd2, 8'h05); wr(2'd1, 8'h34); wr(2'd0, 8'h00);
        peek(2'd1, 8'h33, "R7"); peek(2'd3, 8'h05, "R7"); peek(2'd0, 8'h08, "R7");
        pulses(5); peek(2'd0, 8'h09, "R7");
        alarm_sel = 1'b0;

        // R8 alarm event
        cur_req = "R8";
        evt_cnt = 0;
        pulses(4);
        check_val(evt_cnt, 0, "R8");
        pulses(1);
        peek(2'd1, 8'h34, "R8");
        peek(2'd0, 8'h00, "R8");
        check_val(evt_cnt, 1, "R8");
        pulses(30);
        check_val(evt_cnt, 1, "R8");

        drive(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule